// File: doc/BRIEF.md
# Touch Converter Command Receiver over I2C

This block is the serial front end of a converter-style peripheral. It watches the two I2C wires with a faster system clock, finds START and STOP conditions, and answers to a 7-bit address. The upper five bits of that address are fixed by a parameter. The lower two bits come from two strap pins, read again each time an address byte completes. On a write transfer it acknowledges, takes in the command byte and splits it into a function code, a pending power-down code and a resolution choice. On a read transfer it sends a 16-bit result word, which the surrounding logic places on a port.

The power-down code is not applied on arrival. It waits in a pending register until the conversion engine signals that the current command has finished. At that moment it becomes the active power-down state, and the pen-interrupt enable is derived from it. A command whose function code is 1011 carries a different layout. The block flags such a command and leaves every decoded register as it was.

SDA is only ever pulled low, through an open-drain style output. It is never driven high.

Top module: `touch_cmd_i2c_slave`

## Requirements
- R1: After a synchronous reset: SDA is released; func_sel, pd_pending and pd_mode are 0; res_8bit is 0 (12-bit operation); penirq_en is 1.
- R2: The address byte is sent MSB first. Its bits [7:3] must equal the prefix 10010, bits [2:1] must equal strap_i[1:0], and bit 0 is the direction (1 = master reads, 0 = master writes). When these bits match, the slave pulls SDA low for the ninth clock.
- R3: When either the prefix or the strap bits do not match, the slave gives no acknowledge. It keeps SDA released and ignores all bytes until the next START, so none of its decoded registers change.
- R4: strap_i is read at the completion of every address byte, so a changed strap setting applies from the next transfer onward.
- R5: The slave acknowledges an accepted write data byte and decodes it as a command, unless it is a setup command. For such a command: func_sel takes bits [7:4], pd_pending takes bits [3:2], res_8bit takes bit 1 (1 = 8-bit, 0 = 12-bit), and bit 0 is ignored. cmd_strobe pulses for one cycle.
- R6: pd_mode changes only on a conv_done pulse, and then takes pd_pending. penirq_en is 1 for codes 00 and 10 and 0 for codes 01 and 11.
- R7: A command byte with bits [7:4] = 1011 pulses setup_seen for one cycle and leaves func_sel, pd_pending, res_8bit and cmd_strobe unchanged.
- R8: On a read transfer the slave sends result_word MSB first, as two bytes, high byte first, with the master acknowledging between them.
- R9: If the master does not acknowledge the first read byte, the slave drives nothing further, and a following byte read by the master is all ones.
- R10: A STOP releases SDA and returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_pull_low | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 2 | Pin-strapped low address bits |
| result_word | input | 16 | Word returned on read transfers |
| conv_done | input | 1 | Pulse: current command finished, apply pending power-down |
| func_sel | output | 4 | Decoded function select |
| pd_pending | output | 2 | Power-down code waiting for conv_done |
| pd_mode | output | 2 | Active power-down code |
| res_8bit | output | 1 | 1 = 8-bit resolution, 0 = 12-bit |
| penirq_en | output | 1 | Pen interrupt enable from the active code |
| cmd_strobe | output | 1 | One-cycle pulse per decoded command |
| setup_seen | output | 1 | One-cycle pulse per setup command |

## Verification
If the protocol state or bit counter slips, the fault shows on the wire at the ninth clock of the same byte. A missing or misplaced acknowledge, or a shifted read byte, is visible within about ten SCL periods. A wrong decoded register shows on the decoded outputs a few system cycles after the acknowledge of the command byte. A wrong pending or active power-down state is exposed at the first conv_done pulse through pd_mode and penirq_en. The mismatch and NACK cases check that SDA stays released through the following bytes, and that the register outputs keep their previous values.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_SKIP
  } bus_st_t;
  localparam int BYTE_W = 8;
  localparam logic [3:0] SETUP_FUNC = 4'b1011;
endpackage

// File: rtl/tcs_line_sampler.sv
module tcs_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q    <= '1;
      sda_q    <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_q    <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q    <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_q[SYNC_STAGES-1];
      sda_prev <= sda_q[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_q[SYNC_STAGES-1];
  assign sda_s     = sda_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_evt = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_evt  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/tcs_cmd_decode.sv
module tcs_cmd_decode
  import tcs_pkg::*;
#(
  parameter int FUNC_W = 4,
  parameter int PD_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic              conv_done,
  output logic [FUNC_W-1:0] func_sel,
  output logic [PD_W-1:0]   pd_pending,
  output logic [PD_W-1:0]   pd_mode,
  output logic              res_8bit,
  output logic              penirq_en,
  output logic              cmd_strobe,
  output logic              setup_seen
);
  localparam int FUNC_LSB = BYTE_W - FUNC_W;
  localparam int PD_LSB   = FUNC_LSB - PD_W;

  logic is_setup;
  assign is_setup = (cmd_byte[BYTE_W-1:FUNC_LSB] == SETUP_FUNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      func_sel   <= '0;
      pd_pending <= '0;
      res_8bit   <= 1'b0;
      cmd_strobe <= 1'b0;
      setup_seen <= 1'b0;
    end else begin
      cmd_strobe <= cmd_valid & ~is_setup;
      setup_seen <= cmd_valid & is_setup;
      if (cmd_valid && !is_setup) begin
        func_sel   <= cmd_byte[BYTE_W-1:FUNC_LSB];
        pd_pending <= cmd_byte[FUNC_LSB-1:PD_LSB];
        res_8bit   <= cmd_byte[PD_LSB-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_mode   <= '0;
      penirq_en <= 1'b1;
    end else if (conv_done) begin
      pd_mode   <= pd_pending;
      penirq_en <= ~pd_pending[0];
    end
  end

  assert_setup_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && is_setup) |=> ($stable(func_sel) && $stable(pd_pending) && $stable(res_8bit)));
  assert_pd_deferred_R6: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> $stable(pd_mode));
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe |=> !cmd_strobe);
endmodule

// File: rtl/touch_cmd_i2c_slave.sv
module touch_cmd_i2c_slave
  import tcs_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b10010,
  parameter int STRAP_W     = 2,
  parameter int RESULT_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_pull_low,
  input  logic [STRAP_W-1:0]  strap_i,
  input  logic [RESULT_W-1:0] result_word,
  input  logic                conv_done,
  output logic [3:0]          func_sel,
  output logic [1:0]          pd_pending,
  output logic [1:0]          pd_mode,
  output logic                res_8bit,
  output logic                penirq_en,
  output logic                cmd_strobe,
  output logic                setup_seen
);
  localparam int NBYTES = RESULT_W / BYTE_W;
  localparam int BIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  tcs_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  bus_st_t             state;
  logic [BYTE_W-1:0]   shreg;
  logic [CNT_W-1:0]    bit_cnt;
  logic [RESULT_W-1:0] tx;
  logic [BIDX_W-1:0]   byte_idx;
  logic                rw_read, master_ack, cmd_valid, addr_hit;

  assign addr_hit = (shreg[BYTE_W-1:STRAP_W+1] == ADDR_PREFIX) &&
                    (shreg[STRAP_W:1] == strap_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      shreg        <= '0;
      bit_cnt      <= '0;
      tx           <= '0;
      byte_idx     <= '0;
      rw_read      <= 1'b0;
      master_ack   <= 1'b0;
      cmd_valid    <= 1'b0;
      sda_pull_low <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (start_evt) begin
        state        <= ST_ADDR;
        bit_cnt      <= '0;
        sda_pull_low <= 1'b0;
      end else if (stop_evt) begin
        state        <= ST_IDLE;
        sda_pull_low <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WDAT: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
              bit_cnt <= '0;
              if (state == ST_WDAT) begin
                cmd_valid    <= 1'b1;
                sda_pull_low <= 1'b1;
                state        <= ST_WACK;
              end else if (addr_hit) begin
                rw_read      <= shreg[0];
                sda_pull_low <= 1'b1;
                state        <= ST_AACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_read) begin
                tx           <= result_word;
                byte_idx     <= '0;
                sda_pull_low <= ~result_word[RESULT_W-1];
                state        <= ST_RDAT;
              end else begin
                sda_pull_low <= 1'b0;
                state        <= ST_WDAT;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_pull_low <= 1'b0;
              state        <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              tx <= {tx[RESULT_W-2:0], 1'b0};
              if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                bit_cnt      <= '0;
                sda_pull_low <= 1'b0;
                state        <= ST_RACK;
              end else begin
                bit_cnt      <= bit_cnt + 1'b1;
                sda_pull_low <= ~tx[RESULT_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (master_ack && byte_idx != BIDX_W'(NBYTES - 1)) begin
                byte_idx     <= byte_idx + 1'b1;
                sda_pull_low <= ~tx[RESULT_W-1];
                state        <= ST_RDAT;
              end else begin
                sda_pull_low <= 1'b0;
                state        <= ST_SKIP;
              end
            end
          end
          default: sda_pull_low <= 1'b0;
        endcase
      end
    end
  end

  tcs_cmd_decode u_decode (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(shreg),
    .conv_done(conv_done), .func_sel(func_sel), .pd_pending(pd_pending),
    .pd_mode(pd_mode), .res_8bit(res_8bit), .penirq_en(penirq_en),
    .cmd_strobe(cmd_strobe), .setup_seen(setup_seen)
  );

  assert_skip_released_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !sda_pull_low);
  assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (!sda_pull_low && state == ST_IDLE));
  assert_ack_low_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AACK || state == ST_WACK) |-> sda_pull_low);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_ADDR) |-> !sda_pull_low);
endmodule

// File: tb/touch_cmd_i2c_slave_bench.sv
module touch_cmd_i2c_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull_low;
  logic [1:0] strap = 2'b00;
  logic [15:0] result_word = 16'h0000;
  logic conv_done = 1'b0;
  logic [3:0] func_sel;
  logic [1:0] pd_pending, pd_mode;
  logic res_8bit, penirq_en, cmd_strobe, setup_seen;
  wire sda_line = m_sda & ~sda_pull_low;

  int checks = 0, errors = 0, n_setup = 0, n_strobe = 0, cyc = 0;
  logic [3:0] e_func = 4'h0;
  logic [1:0] e_pd = 2'b00;
  logic e_res = 1'b0;

  always #2.5 clk = ~clk;

  touch_cmd_i2c_slave u_touch_cmd_i2c_slave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_low(sda_pull_low), .strap_i(strap), .result_word(result_word),
    .conv_done(conv_done), .func_sel(func_sel), .pd_pending(pd_pending),
    .pd_mode(pd_mode), .res_8bit(res_8bit), .penirq_en(penirq_en),
    .cmd_strobe(cmd_strobe), .setup_seen(setup_seen)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && setup_seen) n_setup <= n_setup + 1;
    if (!rst && cmd_strobe) n_strobe <= n_strobe + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // bits [25:24] strap, [23:16] address byte, [15:8] command byte, [0] expected ack
  localparam logic [25:0] VEC [7] = '{
    {2'b00, 8'h90, 8'hC6, 7'd0, 1'b1},
    {2'b01, 8'h92, 8'h35, 7'd0, 1'b1},
    {2'b01, 8'h90, 8'h7A, 7'd0, 1'b0},
    {2'b10, 8'h94, 8'h78, 7'd0, 1'b1},
    {2'b11, 8'h96, 8'hAF, 7'd0, 1'b1},
    {2'b11, 8'hB6, 8'h11, 7'd0, 1'b0},
    {2'b10, 8'h94, 8'hB2, 7'd0, 1'b1}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; wait_q();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b1; wait_q();
    m_sda = 1'b1; wait_q();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_q();
      m_scl = 1'b1; wait_q();
      m_scl = 1'b0;
    end
    m_sda = 1'b1; wait_q();
    m_scl = 1'b1; repeat (Q/2) @(negedge clk);
    acked = (sda_line == 1'b0);
    repeat (Q/2) @(negedge clk);
    m_scl = 1'b0;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q();
      m_scl = 1'b1; repeat (Q/2) @(negedge clk);
      b[i] = sda_line;
      repeat (Q/2) @(negedge clk);
      m_scl = 1'b0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1; wait_q();
    m_scl = 1'b1; wait_q();
    m_scl = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic a1, a2;
    logic [7:0] rb0, rb1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sda_pull_low == 1'b0, "R1 sda released", sda_pull_low, 0);
    chk(func_sel == 4'h0 && pd_pending == 2'b00 && pd_mode == 2'b00, "R1 regs zero",
        {func_sel, pd_pending, pd_mode}, 0);
    chk(res_8bit == 1'b0 && penirq_en == 1'b1, "R1 res/penirq", {res_8bit, penirq_en}, 1);

    // vector table: R2 R3 R4 R5 R7
    for (int v = 0; v < 7; v++) begin
      strap = VEC[v][25:24];
      bus_start();
      put_byte(VEC[v][23:16], a1);
      chk(a1 == VEC[v][0], "R2/R3/R4 address ack", a1, VEC[v][0]);
      put_byte(VEC[v][15:8], a2);
      chk(a2 == VEC[v][0], "R5/R3 data ack", a2, VEC[v][0]);
      bus_stop();
      if (VEC[v][0] && VEC[v][15:12] != 4'b1011) begin
        e_func = VEC[v][15:12]; e_pd = VEC[v][11:10]; e_res = VEC[v][9];
      end
      chk(func_sel == e_func, "R5 func_sel", func_sel, e_func);
      chk(pd_pending == e_pd, "R5 pd_pending", pd_pending, e_pd);
      chk(res_8bit == e_res, "R5 res_8bit", res_8bit, e_res);
      chk(pd_mode == 2'b00, "R6 pd_mode held without conv_done", pd_mode, 0);
    end
    chk(n_setup == 1, "R7 setup_seen pulses", n_setup, 1);
    chk(n_strobe == 4, "R5 cmd_strobe pulses", n_strobe, 4);
    chk(sda_pull_low == 1'b0, "R10 released after stop", sda_pull_low, 0);

    // R6: conv_done applies pending 11 -> penirq off
    pulse_done();
    chk(pd_mode == 2'b11 && penirq_en == 1'b0, "R6 apply code 11", {pd_mode, penirq_en}, 6);
    strap = 2'b00;
    bus_start(); put_byte(8'h90, a1); put_byte(8'h28, a2); bus_stop();
    chk(pd_pending == 2'b10 && pd_mode == 2'b11, "R6 pending before done",
        {pd_pending, pd_mode}, 4'b1011);
    pulse_done();
    chk(pd_mode == 2'b10 && penirq_en == 1'b1, "R6 apply code 10", {pd_mode, penirq_en}, 5);

    // R8 read two bytes
    result_word = 16'hA53C; strap = 2'b10;
    bus_start(); put_byte(8'h95, a1);
    chk(a1, "R8 read address ack", a1, 1);
    get_byte(1'b1, rb0); get_byte(1'b0, rb1); bus_stop();
    chk(rb0 == 8'hA5, "R8 high byte", rb0, 8'hA5);
    chk(rb1 == 8'h3C, "R8 low byte", rb1, 8'h3C);

    // R9 NACK after first byte
    result_word = 16'h1200;
    bus_start(); put_byte(8'h95, a1);
    get_byte(1'b0, rb0); get_byte(1'b0, rb1);
    chk(rb0 == 8'h12, "R9 first byte", rb0, 8'h12);
    chk(rb1 == 8'hFF, "R9 no drive after nack", rb1, 8'hFF);
    bus_stop();

    // R10 stop right after address ack; R3 bytes after mismatch not acked
    bus_start(); put_byte(8'h94, a1); bus_stop();
    chk(a1 && sda_pull_low == 1'b0, "R10 stop after ack", sda_pull_low, 0);
    bus_start(); put_byte(8'h92, a1); put_byte(8'h40, a2); put_byte(8'h50, a2); bus_stop();
    chk(!a1 && !a2 && func_sel == 4'h2, "R3 mismatch ignored", func_sel, 2);

    // R1 reset clears decoded state
    @(negedge clk); rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0; @(negedge clk);
    chk(pd_mode == 2'b00 && penirq_en && func_sel == 4'h0, "R1 reset again",
        {pd_mode, penirq_en, func_sel}, 16);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule